// File: doc/BRIEF.md
# Subchannel halt/clear status engine

This block keeps the control and status state of a single I/O subchannel and applies three kinds of event to it: a clear command, a halt command and an unsolicited status event. For each event it updates the activity-control and status-control fields, the device and channel status bytes, the path masks, the command-valid flag and the resume address. An unsolicited event on an enabled subchannel that is not already status-pending also produces a one-cycle interrupt request. The request carries the subsystem identifier, the subchannel number, the interrupt parameter and an interruption word.

Only one channel path exists, so every completed halt or clear records the same path. An upstream function controller sets up the activity state (start-pending, active, suspended and so on) through a load port. All state and all outputs are registered. An event presented in one cycle is visible on the outputs after the next rising clock edge.

Top module: `subch_status_engine`

## Requirements
- R1: A synchronous active-high reset makes every field zero, except the path-operational mask, which becomes 0xFF. The interrupt request is low after reset.
- R2: A clear leaves the last-path-used mask at 0x80 (the only path), the path-operational mask at 0xFF and the path-not-operational flag at 0.
- R3: A clear zeroes the device and channel status bytes and the command-valid flag. It drops clear-pending (activity bit 2), sets status-pending (status bit 0), keeps the other status and activity bits, and leaves the resume address unchanged.
- R4: A halt drops halt-pending (activity bit 1), sets status-pending, zeroes the channel status and the command-valid flag, and sets the last-path-used mask to 0x80.
- R5: A halt writes device status 0x04 (device end) when subchannel-active (activity bit 3) or device-active (bit 4) is set, or when neither start-pending (bit 0) nor suspended (bit 5) is set. Otherwise the device status byte is unchanged.
- R6: A halt sets the resume address to the current command address plus 8 when subchannel-active, device-active or suspended is set. Otherwise the resume address is unchanged.
- R7: When halt and clear arrive in the same cycle, only the clear is performed.
- R8: An unsolicited event on a disabled subchannel changes no state and raises no interrupt.
- R9: An unsolicited event on an enabled subchannel that is not status-pending sets the status field to exactly alert (bit 4) plus status-pending (bit 0). It raises the interrupt request for exactly one cycle, in the same cycle that the new status appears.
- R10: An unsolicited event while status-pending is set changes no state and raises no interrupt.
- R11: With the interrupt request, the block presents the subclass in bits 29:27 of the interruption word (all other bits zero), the subchannel number and the interrupt parameter. It also presents the subsystem identifier: cssid·256 + 8 + ssid·2 + 1 when multiple-image mode is on, and ssid·2 + 1 otherwise. These values hold until the next interrupt.
- R12: Event priority is clear, then halt, then unsolicited event, then load. An unsolicited event in a halt or clear cycle is dropped. A load in any event cycle is dropped. Otherwise a load writes the activity, status, both status bytes, path-operational mask, path-not-operational flag and command-valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Halt command strobe |
| clear_req | input | 1 | Clear command strobe |
| unsol_req | input | 1 | Unsolicited status event strobe |
| enable | input | 1 | Subchannel enabled |
| isc | input | 3 | Interrupt subclass |
| intparm | input | IPW (32) | Interrupt parameter |
| cur_addr | input | AW (32) | Current channel command address |
| mcss_en | input | 1 | Multiple-image identifier mode |
| cssid | input | 8 | Channel subsystem image number |
| ssid | input | 2 | Subchannel set number |
| schno | input | SCHW (16) | Subchannel number |
| ld_req | input | 1 | Load strobe for the control state |
| ld_actl | input | 6 | Activity-control value to load |
| ld_stctl | input | 5 | Status-control value to load |
| ld_dstat | input | 8 | Device status to load |
| ld_cstat | input | 8 | Channel status to load |
| ld_pom | input | 8 | Path-operational mask to load |
| ld_pno | input | 1 | Path-not-operational flag to load |
| ld_cmd_valid | input | 1 | Command-valid flag to load |
| actl | output | 6 | Activity-control field |
| stctl | output | 5 | Status-control field |
| dstat | output | 8 | Device status byte |
| cstat | output | 8 | Channel status byte |
| lpum | output | 8 | Last-path-used mask |
| pom | output | 8 | Path-operational mask |
| pno | output | 1 | Path-not-operational flag |
| cmd_valid | output | 1 | Last command valid |
| resume_addr | output | AW (32) | Resume (saved program) address |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_sid | output | 16 | Subsystem identifier |
| irq_schno | output | SCHW (16) | Subchannel number |
| irq_parm | output | IPW (32) | Interrupt parameter |
| irq_word | output | 32 | Interruption word |

## Verification
The bench targets the halt decision table. Start-pending without activity must keep the old device status, suspended alone must advance the resume address but not report device end, and an idle subchannel must report device end without advancing; a design that merges the two conditions gets one of these wrong. Simultaneous halt and clear show whether clear really wins: a halt leaking through would leave device end or a moved resume address. Unsolicited events are sent while disabled, while already pending, and alongside halts and loads; a faulty design would overwrite pending status, fire a second interrupt or let a load slip through. Both identifier modes are driven to expose a misplaced bit in the subsystem identifier.

// File: rtl/sce_pkg.sv
package sce_pkg;
  localparam int ACT_W = 6;
  localparam int ST_W  = 5;

  // activity-control bit positions
  localparam int A_START  = 0;
  localparam int A_HALTP  = 1;
  localparam int A_CLRP   = 2;
  localparam int A_SUBACT = 3;
  localparam int A_DEVACT = 4;
  localparam int A_SUSP   = 5;

  // status-control bit positions
  localparam int S_PEND  = 0;
  localparam int S_SEC   = 1;
  localparam int S_PRIM  = 2;
  localparam int S_INTER = 3;
  localparam int S_ALERT = 4;

  localparam logic [7:0] DSTAT_DEV_END = 8'h04;
  localparam logic [7:0] PATH_SOLE     = 8'h80;
  localparam logic [7:0] PATH_ALL      = 8'hFF;

  localparam int ISC_W        = 3;
  localparam int WORD_W       = 32;
  localparam int WORD_ISC_LSB = 27;
  localparam int SID_W        = 16;

  typedef struct packed {
    logic [ACT_W-1:0] actl;
    logic [ST_W-1:0]  stctl;
    logic [7:0]       dstat;
    logic [7:0]       cstat;
    logic [7:0]       lpum;
    logic [7:0]       pom;
    logic             pno;
    logic             cmd_valid;
  } sch_ctl_t;

  function automatic logic [SID_W-1:0] make_sid(input logic mcss,
                                                input logic [7:0] css_no,
                                                input logic [1:0] set_no);
    if (mcss) return {css_no, 4'b0000, 1'b1, set_no, 1'b1};
    return {13'd0, set_no, 1'b1};
  endfunction
endpackage

// File: rtl/sce_func_unit.sv
module sce_func_unit
  import sce_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CMD_BYTES = 8
) (
  input  sch_ctl_t        cur,
  input  logic [AW-1:0]   resume_cur,
  input  logic [AW-1:0]   cur_addr,
  input  logic            halt,
  input  logic            clear,
  output sch_ctl_t        nxt,
  output logic [AW-1:0]   resume_nxt
);
  logic busy, parked, devend_ok, adv_ok;

  always_comb begin
    busy      = cur.actl[A_SUBACT] | cur.actl[A_DEVACT];
    parked    = cur.actl[A_START] | cur.actl[A_SUSP];
    devend_ok = busy | ~parked;
    adv_ok    = busy | cur.actl[A_SUSP];
  end

  always_comb begin
    nxt        = cur;
    resume_nxt = resume_cur;
    if (clear) begin
      nxt.pom           = PATH_ALL;
      nxt.pno           = 1'b0;
      nxt.cmd_valid     = 1'b0;
      nxt.actl[A_CLRP]  = 1'b0;
      nxt.stctl[S_PEND] = 1'b1;
      nxt.dstat         = '0;
      nxt.cstat         = '0;
      nxt.lpum          = PATH_SOLE;
    end else if (halt) begin
      nxt.cmd_valid     = 1'b0;
      nxt.actl[A_HALTP] = 1'b0;
      nxt.stctl[S_PEND] = 1'b1;
      if (devend_ok) nxt.dstat = DSTAT_DEV_END;
      if (adv_ok) resume_nxt = cur_addr + AW'(CMD_BYTES);
      nxt.cstat         = '0;
      nxt.lpum          = PATH_SOLE;
    end
  end
endmodule

// File: rtl/sce_irq_unit.sv
module sce_irq_unit
  import sce_pkg::*;
#(
  parameter int IPW  = 32,
  parameter int SCHW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              mcss_en,
  input  logic [7:0]        cssid,
  input  logic [1:0]        ssid,
  input  logic [SCHW-1:0]   schno,
  input  logic [IPW-1:0]    intparm,
  input  logic [ISC_W-1:0]  isc,
  output logic              irq_req,
  output logic [SID_W-1:0]  irq_sid,
  output logic [SCHW-1:0]   irq_schno,
  output logic [IPW-1:0]    irq_parm,
  output logic [WORD_W-1:0] irq_word
);
  localparam int HI_PAD = WORD_W - WORD_ISC_LSB - ISC_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      irq_sid   <= '0;
      irq_schno <= '0;
      irq_parm  <= '0;
      irq_word  <= '0;
    end else begin
      irq_req <= fire;
      if (fire) begin
        irq_sid   <= make_sid(mcss_en, cssid, ssid);
        irq_schno <= schno;
        irq_parm  <= intparm;
        irq_word  <= {{HI_PAD{1'b0}}, isc, {WORD_ISC_LSB{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/subch_status_engine.sv
module subch_status_engine
  import sce_pkg::*;
#(
  parameter int AW        = 32,
  parameter int IPW       = 32,
  parameter int SCHW      = 16,
  parameter int CMD_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_req,
  input  logic              clear_req,
  input  logic              unsol_req,
  input  logic              enable,
  input  logic [2:0]        isc,
  input  logic [IPW-1:0]    intparm,
  input  logic [AW-1:0]     cur_addr,
  input  logic              mcss_en,
  input  logic [7:0]        cssid,
  input  logic [1:0]        ssid,
  input  logic [SCHW-1:0]   schno,
  input  logic              ld_req,
  input  logic [5:0]        ld_actl,
  input  logic [4:0]        ld_stctl,
  input  logic [7:0]        ld_dstat,
  input  logic [7:0]        ld_cstat,
  input  logic [7:0]        ld_pom,
  input  logic              ld_pno,
  input  logic              ld_cmd_valid,
  output logic [5:0]        actl,
  output logic [4:0]        stctl,
  output logic [7:0]        dstat,
  output logic [7:0]        cstat,
  output logic [7:0]        lpum,
  output logic [7:0]        pom,
  output logic              pno,
  output logic              cmd_valid,
  output logic [AW-1:0]     resume_addr,
  output logic              irq_req,
  output logic [15:0]       irq_sid,
  output logic [SCHW-1:0]   irq_schno,
  output logic [IPW-1:0]    irq_parm,
  output logic [31:0]       irq_word
);
  sch_ctl_t      st_q, st_d, f_st;
  logic [AW-1:0] res_q, res_d, f_res;
  logic          cmd_evt, fire_unsol;

  sce_func_unit #(.AW(AW), .CMD_BYTES(CMD_BYTES)) u_func (
    .cur        (st_q),
    .resume_cur (res_q),
    .cur_addr   (cur_addr),
    .halt       (halt_req),
    .clear      (clear_req),
    .nxt        (f_st),
    .resume_nxt (f_res)
  );

  assign cmd_evt    = halt_req | clear_req;
  assign fire_unsol = unsol_req & enable & ~st_q.stctl[S_PEND] & ~cmd_evt;

  always_comb begin
    st_d  = st_q;
    res_d = res_q;
    if (cmd_evt) begin
      st_d  = f_st;
      res_d = f_res;
    end else if (fire_unsol) begin
      st_d.stctl          = '0;
      st_d.stctl[S_ALERT] = 1'b1;
      st_d.stctl[S_PEND]  = 1'b1;
    end else if (ld_req) begin
      st_d.actl      = ld_actl;
      st_d.stctl     = ld_stctl;
      st_d.dstat     = ld_dstat;
      st_d.cstat     = ld_cstat;
      st_d.pom       = ld_pom;
      st_d.pno       = ld_pno;
      st_d.cmd_valid = ld_cmd_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '{actl: '0, stctl: '0, dstat: '0, cstat: '0, lpum: '0,
                pom: PATH_ALL, pno: 1'b0, cmd_valid: 1'b0};
      res_q <= '0;
    end else begin
      st_q  <= st_d;
      res_q <= res_d;
    end
  end

  sce_irq_unit #(.IPW(IPW), .SCHW(SCHW)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire_unsol),
    .mcss_en   (mcss_en),
    .cssid     (cssid),
    .ssid      (ssid),
    .schno     (schno),
    .intparm   (intparm),
    .isc       (isc),
    .irq_req   (irq_req),
    .irq_sid   (irq_sid),
    .irq_schno (irq_schno),
    .irq_parm  (irq_parm),
    .irq_word  (irq_word)
  );

  assign actl        = st_q.actl;
  assign stctl       = st_q.stctl;
  assign dstat       = st_q.dstat;
  assign cstat       = st_q.cstat;
  assign lpum        = st_q.lpum;
  assign pom         = st_q.pom;
  assign pno         = st_q.pno;
  assign cmd_valid   = st_q.cmd_valid;
  assign resume_addr = res_q;

  p_clear_paths_r2: assert property (@(posedge clk) disable iff (rst)
    clear_req |=> (lpum == PATH_SOLE) && (pom == PATH_ALL) && !pno);

  p_clear_status_r3: assert property (@(posedge clk) disable iff (rst)
    clear_req |=> (dstat == 8'h00) && (cstat == 8'h00) && stctl[S_PEND] && !actl[A_CLRP]);

  p_halt_done_r4: assert property (@(posedge clk) disable iff (rst)
    (halt_req && !clear_req) |=> stctl[S_PEND] && !actl[A_HALTP] && (cstat == 8'h00) && !cmd_valid);

  p_halt_resume_r6: assert property (@(posedge clk) disable iff (rst)
    (halt_req && !clear_req && (actl[A_SUBACT] || actl[A_DEVACT] || actl[A_SUSP]))
      |=> resume_addr == $past(cur_addr) + AW'(CMD_BYTES));

  p_unsol_off_r8: assert property (@(posedge clk) disable iff (rst)
    (unsol_req && !enable && !cmd_evt && !ld_req) |=> $stable(stctl) && !irq_req);

  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    irq_req |=> !irq_req);

  p_irq_status_r9: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> stctl == 5'b10001);

  p_unsol_pend_r10: assert property (@(posedge clk) disable iff (rst)
    (unsol_req && stctl[S_PEND] && !cmd_evt && !ld_req) |=> $stable(stctl) && !irq_req);
endmodule

// File: tb/subch_status_engine_test.sv
module subch_status_engine_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_req = 0, clear_req = 0, unsol_req = 0, enable = 0;
  logic [2:0] isc = 0;
  logic [31:0] intparm = 0, cur_addr = 0;
  logic mcss_en = 0;
  logic [7:0] cssid = 0;
  logic [1:0] ssid = 0;
  logic [15:0] schno = 0;
  logic ld_req = 0;
  logic [5:0] ld_actl = 0;
  logic [4:0] ld_stctl = 0;
  logic [7:0] ld_dstat = 0, ld_cstat = 0, ld_pom = 0;
  logic ld_pno = 0, ld_cmd_valid = 0;

  logic [5:0] actl;
  logic [4:0] stctl;
  logic [7:0] dstat, cstat, lpum, pom;
  logic pno, cmd_valid;
  logic [31:0] resume_addr;
  logic irq_req;
  logic [15:0] irq_sid, irq_schno;
  logic [31:0] irq_parm, irq_word;

  subch_status_engine uut (
    .clk(clk), .rst(rst), .halt_req(halt_req), .clear_req(clear_req),
    .unsol_req(unsol_req), .enable(enable), .isc(isc), .intparm(intparm),
    .cur_addr(cur_addr), .mcss_en(mcss_en), .cssid(cssid), .ssid(ssid),
    .schno(schno), .ld_req(ld_req), .ld_actl(ld_actl), .ld_stctl(ld_stctl),
    .ld_dstat(ld_dstat), .ld_cstat(ld_cstat), .ld_pom(ld_pom), .ld_pno(ld_pno),
    .ld_cmd_valid(ld_cmd_valid), .actl(actl), .stctl(stctl), .dstat(dstat),
    .cstat(cstat), .lpum(lpum), .pom(pom), .pno(pno), .cmd_valid(cmd_valid),
    .resume_addr(resume_addr), .irq_req(irq_req), .irq_sid(irq_sid),
    .irq_schno(irq_schno), .irq_parm(irq_parm), .irq_word(irq_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // expected state
  logic [5:0] e_actl;
  logic [4:0] e_stctl;
  logic [7:0] e_dstat, e_cstat, e_lpum, e_pom;
  logic e_pno, e_cv, e_irq;
  logic [31:0] e_res, e_parm, e_word;
  logic [15:0] e_sid, e_sch;

  int nvec = 0;
  int nfail = 0;
  bit vec_bad;
  bit done = 0;

  function automatic logic [15:0] exp_sid(logic m, logic [7:0] c, logic [1:0] s);
    int v;
    if (m) v = int'(c) * 256 + 8 + int'(s) * 2 + 1;
    else   v = int'(s) * 2 + 1;
    return 16'(v);
  endfunction

  function automatic logic [31:0] exp_word(logic [2:0] k);
    return 32'(k) << 27;
  endfunction

  task automatic model_step();
    e_irq = 1'b0;
    if (rst) begin
      e_actl = 0; e_stctl = 0; e_dstat = 0; e_cstat = 0; e_lpum = 0;
      e_pom = 8'hFF; e_pno = 0; e_cv = 0; e_res = 0;
      e_sid = 0; e_sch = 0; e_parm = 0; e_word = 0;
    end else if (clear_req) begin
      e_lpum = 8'h80; e_pom = 8'hFF; e_pno = 0; e_cv = 0;
      e_actl[2] = 0; e_stctl[0] = 1; e_dstat = 0; e_cstat = 0;
    end else if (halt_req) begin
      logic act, susp, strt;
      act  = e_actl[3] | e_actl[4];
      susp = e_actl[5];
      strt = e_actl[0];
      if (act || (!strt && !susp)) e_dstat = 8'h04;
      if (act || susp) e_res = cur_addr + 32'd8;
      e_cv = 0; e_actl[1] = 0; e_stctl[0] = 1; e_cstat = 0; e_lpum = 8'h80;
    end else if (unsol_req && enable && !e_stctl[0]) begin
      e_stctl = 5'b10001;
      e_irq = 1'b1;
      e_sid = exp_sid(mcss_en, cssid, ssid);
      e_sch = schno; e_parm = intparm; e_word = exp_word(isc);
    end else if (ld_req) begin
      e_actl = ld_actl; e_stctl = ld_stctl; e_dstat = ld_dstat;
      e_cstat = ld_cstat; e_pom = ld_pom; e_pno = ld_pno; e_cv = ld_cmd_valid;
    end
  endtask

  task automatic cmp(string tag, string fld, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      vec_bad = 1;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, fld, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    vec_bad = 0;
    nvec++;
    cmp(tag, "actl", 32'(actl), 32'(e_actl));
    cmp(tag, "stctl", 32'(stctl), 32'(e_stctl));
    cmp(tag, "dstat", 32'(dstat), 32'(e_dstat));
    cmp(tag, "cstat", 32'(cstat), 32'(e_cstat));
    cmp(tag, "lpum", 32'(lpum), 32'(e_lpum));
    cmp(tag, "pom", 32'(pom), 32'(e_pom));
    cmp(tag, "pno", 32'(pno), 32'(e_pno));
    cmp(tag, "cmd_valid", 32'(cmd_valid), 32'(e_cv));
    cmp(tag, "resume", resume_addr, e_res);
    cmp(tag, "irq_req", 32'(irq_req), 32'(e_irq));
    cmp(tag, "irq_sid", 32'(irq_sid), 32'(e_sid));
    cmp(tag, "irq_schno", 32'(irq_schno), 32'(e_sch));
    cmp(tag, "irq_parm", irq_parm, e_parm);
    cmp(tag, "irq_word", irq_word, e_word);
    if (vec_bad) nfail++;
  endtask

  task automatic idle_inputs();
    halt_req = 0; clear_req = 0; unsol_req = 0; ld_req = 0;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all(tag);
    idle_inputs();
  endtask

  task automatic load(logic [5:0] a, logic [4:0] s, logic [7:0] d, logic [7:0] c,
                      logic [7:0] p, logic n, logic v);
    ld_req = 1; ld_actl = a; ld_stctl = s; ld_dstat = d; ld_cstat = c;
    ld_pom = p; ld_pno = n; ld_cmd_valid = v;
    step("R12 load");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog expired, actual=hung expected=finished");
    nfail++;
    finish_run();
  end

  initial begin
    void'($urandom(32'h5A17C0DE));
    @(negedge clk);
    rst = 1;
    step("R1 reset");
    step("R1 reset");
    rst = 0;
    step("R1 idle after reset");

    // load then clear
    load(6'b000111, 5'b00100, 8'h55, 8'h33, 8'h0F, 1'b1, 1'b1);
    cur_addr = 32'h0000_1000;
    clear_req = 1; step("R2 R3 clear");

    // halt with start-pending only: no device end, no advance
    load(6'b000011, 5'b00000, 8'h00, 8'h11, 8'h0F, 1'b0, 1'b1);
    cur_addr = 32'h0000_2000;
    halt_req = 1; step("R4 R5 R6 halt start-pending");

    // halt suspended: no device end, advance
    load(6'b100010, 5'b00000, 8'h00, 8'h22, 8'h0F, 1'b0, 1'b1);
    cur_addr = 32'h0000_3000;
    halt_req = 1; step("R5 R6 halt suspended");

    // halt subchannel active: device end and advance
    load(6'b001011, 5'b00000, 8'h00, 8'h22, 8'h0F, 1'b0, 1'b1);
    cur_addr = 32'h0000_4000;
    halt_req = 1; step("R5 R6 halt active");

    // halt device active with suspend
    load(6'b110000, 5'b00000, 8'h10, 8'h22, 8'h0F, 1'b0, 1'b1);
    cur_addr = 32'hFFFF_FFFC;
    halt_req = 1; step("R5 R6 halt device active wrap");

    // halt idle: device end, no advance
    load(6'b000000, 5'b00000, 8'h00, 8'h00, 8'h0F, 1'b0, 1'b1);
    cur_addr = 32'h0000_5000;
    halt_req = 1; step("R5 R6 halt idle");

    // halt and clear together
    load(6'b001110, 5'b00000, 8'h55, 8'h66, 8'h0F, 1'b1, 1'b1);
    cur_addr = 32'h0000_6000;
    halt_req = 1; clear_req = 1; step("R7 clear beats halt");

    // unsolicited on disabled subchannel
    load(6'b000000, 5'b00110, 8'h00, 8'h00, 8'hFF, 1'b0, 1'b0);
    enable = 0; unsol_req = 1; step("R8 unsolicited disabled");

    // unsolicited enabled, not pending
    enable = 1; isc = 3'd5; intparm = 32'hCAFE_F00D; schno = 16'h1234;
    mcss_en = 1; cssid = 8'hFE; ssid = 2'd3;
    unsol_req = 1; step("R9 R11 unsolicited fires");
    step("R9 pulse ends");

    // unsolicited while pending
    isc = 3'd2; intparm = 32'h1; schno = 16'h9;
    unsol_req = 1; step("R10 unsolicited while pending");

    // unsolicited with halt in same cycle
    load(6'b000000, 5'b00000, 8'h00, 8'h00, 8'hFF, 1'b0, 1'b1);
    unsol_req = 1; halt_req = 1; step("R12 halt beats unsolicited");

    // unsolicited with load in same cycle; single-image identifier
    load(6'b000000, 5'b00000, 8'h00, 8'h00, 8'hFF, 1'b0, 1'b0);
    mcss_en = 0; ssid = 2'd2; isc = 3'd7;
    unsol_req = 1; ld_req = 1; ld_stctl = 5'b00000; ld_dstat = 8'hAA;
    step("R11 R12 unsolicited beats load");

    // load during clear is dropped
    ld_req = 1; ld_dstat = 8'h77; ld_pom = 8'h01; clear_req = 1;
    step("R12 clear beats load");

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      rst       = ($urandom % 400) == 0;
      clear_req = ($urandom % 10) == 0;
      halt_req  = ($urandom % 6) == 0;
      unsol_req = ($urandom % 4) == 0;
      enable    = ($urandom % 4) != 0;
      ld_req    = ($urandom % 3) == 0;
      ld_actl   = 6'($urandom);
      ld_stctl  = 5'($urandom) & {4'hF, 1'($urandom % 3 == 0)};
      ld_dstat  = 8'($urandom);
      ld_cstat  = 8'($urandom);
      ld_pom    = 8'($urandom);
      ld_pno    = 1'($urandom);
      ld_cmd_valid = 1'($urandom);
      isc       = 3'($urandom);
      intparm   = $urandom;
      cur_addr  = $urandom;
      mcss_en   = 1'($urandom);
      cssid     = 8'($urandom);
      ssid      = 2'($urandom);
      schno     = 16'($urandom);
      step(rst ? "R1 random" : "R2 R4 R5 R6 R7 R9 R10 R11 R12 random");
    end
    rst = 0;
    finish_run();
  end
endmodule